// File: doc/BRIEF.md
# Bus Cycle Status Decoder

This block turns the 3-bit bus-cycle status code from a processor into the
separate command and timing strobes of one bus cycle. The processor only
announces the kind of cycle it wants. The decoder detects when the status
leaves the passive code and then steps through the T-states. It issues the
address latch pulse, the active-low read, write and interrupt-acknowledge
commands, the data transceiver enable and the data direction line.

The status is sampled on every rising clock edge. A cycle begins when the
status code moves from passive (111) to any other value. The code is latched
at that edge and the cycle then runs T1 through the last T-state. Changes on
the status lines while a cycle runs are ignored. The number of T-states is a
parameter and defaults to four. The outputs are decoded from registered state.

Top module: `bus_status_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is idle: all five active-low commands are high, ale_o is 0, data_en_o is 0 and dir_o is 1.
- R2: A cycle starts at a rising edge where the block is idle, status_i is not 111, and status_i was 111 at the previous edge (or reset was just released). T1 begins at that edge, the cycle lasts T_STATES states (T1..T4 by default), and the block then returns to idle.
- R3: ale_o is 1 for exactly the T1 state of every started cycle, including halt, and is 0 at all other times.
- R4: The latched code selects the command: 101 and 100 drive mem_rd_no, 110 drives mem_wr_no, 001 drives io_rd_no, 010 drives io_wr_no and 000 drives int_ack_no. The selected command is low from T2 through the last T-state and high at all other times.
- R5: data_en_o is 1 from T2 through the last T-state for codes 000, 001, 010, 100, 101 and 110, and 0 otherwise.
- R6: dir_o is 0 from T1 through the last T-state for the receive codes 000, 001, 100 and 101, and 1 at all other times, including write cycles, halt cycles and idle.
- R7: Halt (011) and passive (111) produce no command and no data enable. A status held at 111 starts no cycle.
- R8: After a cycle ends, a status still held at a non-passive code starts no new cycle until it has been 111 at a sampling edge. Status changes during a cycle do not alter that cycle's command.
- R9: At most one command output is low at any time, and no command is low while ale_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Bus-cycle status code; 111 is passive |
| mem_rd_no | output | 1 | Memory read command, active low |
| mem_wr_no | output | 1 | Memory write command, active low |
| io_rd_no | output | 1 | I/O read command, active low |
| io_wr_no | output | 1 | I/O write command, active low |
| int_ack_no | output | 1 | Interrupt acknowledge command, active low |
| ale_o | output | 1 | Address latch enable pulse in T1 |
| data_en_o | output | 1 | Data transceiver enable |
| dir_o | output | 1 | Data direction: 1 transmit, 0 receive |

## Verification
The bench builds the block with the default T_STATES of 4. With that value every strobe edge of the T1..T4 sequence can be compared state by state against a table computed in the bench, for all eight status codes. The bench also drives a status that is held past the end of a cycle and a status that changes in the middle of a cycle. These two cases exercise the passive-to-active start rule and the latching of the code at T1.

// File: rtl/bus_status_pkg.sv
package bus_status_pkg;

  localparam int unsigned STATUS_W = 3;
  localparam int unsigned NUM_CMD  = 5;

  typedef enum logic [STATUS_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MRD     = 3'b101,
    ST_MWR     = 3'b110,
    ST_PASSIVE = 3'b111
  } status_e;

  // command vector bit positions
  localparam int unsigned CMD_MRD  = 0;
  localparam int unsigned CMD_MWR  = 1;
  localparam int unsigned CMD_IORD = 2;
  localparam int unsigned CMD_IOWR = 3;
  localparam int unsigned CMD_INTA = 4;

  typedef struct packed {
    logic [NUM_CMD-1:0] cmd;
    logic               uses_data;
    logic               is_read;
  } cycle_sel_t;

endpackage

// File: rtl/bsd_decode.sv
module bsd_decode
  import bus_status_pkg::*;
(
  input  status_e    code_i,
  output cycle_sel_t sel_o
);

  always_comb begin
    sel_o = '0;
    unique case (code_i)
      ST_INTA:  begin sel_o.cmd[CMD_INTA] = 1'b1; sel_o.uses_data = 1'b1; sel_o.is_read = 1'b1; end
      ST_IORD:  begin sel_o.cmd[CMD_IORD] = 1'b1; sel_o.uses_data = 1'b1; sel_o.is_read = 1'b1; end
      ST_IOWR:  begin sel_o.cmd[CMD_IOWR] = 1'b1; sel_o.uses_data = 1'b1; end
      ST_FETCH,
      ST_MRD:   begin sel_o.cmd[CMD_MRD]  = 1'b1; sel_o.uses_data = 1'b1; sel_o.is_read = 1'b1; end
      ST_MWR:   begin sel_o.cmd[CMD_MWR]  = 1'b1; sel_o.uses_data = 1'b1; end
      default:  sel_o = '0; // halt, passive
    endcase
  end

endmodule

// File: rtl/bsd_sequencer.sv
module bsd_sequencer
  import bus_status_pkg::*;
#(
  parameter int unsigned T_STATES = 4,
  localparam int unsigned TW = $clog2(T_STATES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  status_e       status_i,
  output logic [TW-1:0] tstate_o,
  output status_e       code_o
);

  localparam logic [TW-1:0] T_LAST = TW'(T_STATES);

  logic [TW-1:0] tstate_q;
  status_e       code_q;
  logic          prev_passive_q;
  logic          start;

  assign start = (tstate_q == '0) && prev_passive_q && (status_i != ST_PASSIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tstate_q       <= '0;
      code_q         <= ST_PASSIVE;
      prev_passive_q <= 1'b1;
    end else begin
      prev_passive_q <= (status_i == ST_PASSIVE);
      if (start) begin
        tstate_q <= TW'(1);
        code_q   <= status_i;
      end else if (tstate_q == T_LAST) begin
        tstate_q <= '0;
        code_q   <= ST_PASSIVE;
      end else if (tstate_q != '0) begin
        tstate_q <= tstate_q + TW'(1);
      end
    end
  end

  assign tstate_o = tstate_q;
  assign code_o   = code_q;

endmodule

// File: rtl/bsd_strobes.sv
module bsd_strobes
  import bus_status_pkg::*;
#(
  parameter int unsigned T_STATES = 4,
  localparam int unsigned TW = $clog2(T_STATES + 1)
) (
  input  logic [TW-1:0]      tstate_i,
  input  cycle_sel_t         sel_i,
  output logic [NUM_CMD-1:0] cmd_no,
  output logic               ale_o,
  output logic               data_en_o,
  output logic               dir_o
);

  logic in_cycle;
  logic cmd_window;

  assign in_cycle   = (tstate_i != '0);
  assign cmd_window = (tstate_i >= TW'(2));
  assign ale_o      = (tstate_i == TW'(1));
  assign data_en_o  = cmd_window && sel_i.uses_data;
  assign dir_o      = !(in_cycle && sel_i.is_read);

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
    assign cmd_no[i] = !(cmd_window && sel_i.cmd[i]);
  end

endmodule

// File: rtl/bus_status_decoder.sv
module bus_status_decoder
  import bus_status_pkg::*;
#(
  parameter int unsigned T_STATES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STATUS_W-1:0] status_i,
  output logic                mem_rd_no,
  output logic                mem_wr_no,
  output logic                io_rd_no,
  output logic                io_wr_no,
  output logic                int_ack_no,
  output logic                ale_o,
  output logic                data_en_o,
  output logic                dir_o
);

  localparam int unsigned TW = $clog2(T_STATES + 1);

  logic [TW-1:0]      tstate;
  status_e            code;
  cycle_sel_t         sel;
  logic [NUM_CMD-1:0] cmd_n;

  bsd_sequencer #(.T_STATES(T_STATES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_e'(status_i)),
    .tstate_o (tstate),
    .code_o   (code)
  );

  bsd_decode u_dec (
    .code_i (code),
    .sel_o  (sel)
  );

  bsd_strobes #(.T_STATES(T_STATES)) u_stb (
    .tstate_i  (tstate),
    .sel_i     (sel),
    .cmd_no    (cmd_n),
    .ale_o     (ale_o),
    .data_en_o (data_en_o),
    .dir_o     (dir_o)
  );

  assign mem_rd_no  = cmd_n[CMD_MRD];
  assign mem_wr_no  = cmd_n[CMD_MWR];
  assign io_rd_no   = cmd_n[CMD_IORD];
  assign io_wr_no   = cmd_n[CMD_IOWR];
  assign int_ack_no = cmd_n[CMD_INTA];

endmodule

// File: rtl/bsd_checker.sv
module bsd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] status_i,
  input logic       mem_rd_no,
  input logic       mem_wr_no,
  input logic       io_rd_no,
  input logic       io_wr_no,
  input logic       int_ack_no,
  input logic       ale_o,
  input logic       data_en_o,
  input logic       dir_o
);

  logic [4:0] cmd_n;
  assign cmd_n = {int_ack_no, io_wr_no, io_rd_no, mem_wr_no, mem_rd_no};

  // R9
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cmd_n));

  // R9
  no_cmd_in_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (&cmd_n));

  // R3
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R2
  ale_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ($past(status_i) != 3'b111));

  // R5
  cmd_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cmd_n) |-> data_en_o);

  // R6
  write_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wr_no || !io_wr_no) |-> dir_o);

  // R6
  read_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rd_no || !io_rd_no || !int_ack_no) |-> !dir_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> ((&cmd_n) && !ale_o && !data_en_o && dir_o));

endmodule

bind bus_status_decoder bsd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_i),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .io_rd_no   (io_rd_no),
  .io_wr_no   (io_wr_no),
  .int_ack_no (int_ack_no),
  .ale_o      (ale_o),
  .data_en_o  (data_en_o),
  .dir_o      (dir_o)
);

// File: tb/sim_bus_status_decoder.sv
`timescale 1ns/1ps
module sim_bus_status_decoder;

  localparam int T_STATES = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] status_i = 3'b111;
  logic mem_rd_no, mem_wr_no, io_rd_no, io_wr_no, int_ack_no, ale_o, data_en_o, dir_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bus_status_decoder #(.T_STATES(T_STATES)) u0 (.*);

  // {mrd, mwr, iord, iowr, inta, ale, den, dir}
  function automatic logic [7:0] expv(input logic [2:0] c, input int t);
    logic act, rd;
    act = (t >= 2);
    rd  = (c == 3'd0) || (c == 3'd1) || (c == 3'd4) || (c == 3'd5);
    expv[7] = !(act && (c == 3'd4 || c == 3'd5));
    expv[6] = !(act && c == 3'd6);
    expv[5] = !(act && c == 3'd1);
    expv[4] = !(act && c == 3'd2);
    expv[3] = !(act && c == 3'd0);
    expv[2] = (t == 1);
    expv[1] = act && (c != 3'd3) && (c != 3'd7);
    expv[0] = !((t >= 1) && rd);
  endfunction

  function automatic logic [7:0] obs();
    return {mem_rd_no, mem_wr_no, io_rd_no, io_wr_no, int_ack_no, ale_o, data_en_o, dir_o};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (obs() !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, obs(), exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk_i); check("R1 in reset", expv(3'd7, 0));
    rst_ni = 1'b1;
    @(negedge clk_i); check("R1 after release", expv(3'd7, 0));
  endtask

  // one full cycle; status returns to passive after T1
  task automatic test_cycle(input logic [2:0] c, input string tag);
    @(negedge clk_i); status_i = c;
    for (int t = 1; t <= T_STATES; t++) begin
      @(negedge clk_i);
      check(tag, expv(c, t));
      if (t == 1) status_i = 3'b111;
    end
    @(negedge clk_i); check({tag, " end R2"}, expv(3'd7, 0));
  endtask

  task automatic test_passive();
    status_i = 3'b111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); check("R7 passive", expv(3'd7, 0));
    end
  endtask

  task automatic test_hold();
    @(negedge clk_i); status_i = 3'd5;
    for (int t = 1; t <= T_STATES; t++) begin
      @(negedge clk_i); check("R8 hold cycle", expv(3'd5, t));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); check("R8 hold no restart", expv(3'd7, 0));
    end
    status_i = 3'b111;
    @(negedge clk_i); check("R8 passive idle", expv(3'd7, 0));
    status_i = 3'd6;
    for (int t = 1; t <= T_STATES; t++) begin
      @(negedge clk_i); check("R8 restart write", expv(3'd6, t));
    end
    status_i = 3'b111;
    @(negedge clk_i); check("R8 restart end", expv(3'd7, 0));
  endtask

  task automatic test_midchange();
    @(negedge clk_i); status_i = 3'd1;
    for (int t = 1; t <= T_STATES; t++) begin
      @(negedge clk_i); check("R8 mid change", expv(3'd1, t));
      status_i = (t % 2 == 1) ? 3'd6 : 3'd2;
    end
    @(negedge clk_i); check("R8 mid change end", expv(3'd7, 0));
    status_i = 3'b111;
    @(negedge clk_i); check("R8 mid change idle", expv(3'd7, 0));
  endtask

  initial begin
    test_reset();
    test_passive();
    test_cycle(3'd5, "R4 mem read");
    test_cycle(3'd4, "R4 code fetch");
    test_cycle(3'd6, "R5 mem write");
    test_cycle(3'd1, "R6 io read");
    test_cycle(3'd2, "R5 io write");
    test_cycle(3'd0, "R3 int ack");
    test_cycle(3'd3, "R7 halt");
    test_hold();
    test_midchange();
    test_cycle(3'd5, "R4 read after");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog R2 actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule